// File: doc/BRIEF.md
# Receive Mailbox Bank with Host Locking

This block is the receive storage of a CAN-style controller. It keeps a bank of message buffers, each made of four 32-bit words: a control word (state code, length, timestamp), an identifier word and two data words. Frames arrive on a simple one-cycle frame input. Each frame is written into the lowest-numbered buffer that is armed as empty, and the interrupt flag of that buffer is raised. Writing a frame takes two cycles. In the first cycle the buffer shows a busy code. In the second cycle the contents and the final code are committed.

A host register port reads and writes the buffer words and the flag and mask registers. It can also read a free-running 16-bit timer. Reading the control word of a buffer that is not empty locks that buffer, so the receiver does not touch it while the host copies it out. A timer read releases the lock. When no buffer is empty, a frame overwrites the most recently filled buffer and marks it as overrun. If that buffer is locked, busy or not full, the frame is dropped and a saturating lost-frame counter is incremented.

Host reads return data on `hst_rdata` one cycle after the request, with `hst_rvalid` high. The host address is 9 bits wide. Buffer `b` word `w` sits at address `b*4+w`, where word 0 is control, 1 is identifier, 2 is data 0 and 3 is data 1. The flag words start at 0x100, the mask words at 0x110, the timer is at 0x120 and the lost counter at 0x121.

Top module: `rmb_bank`

## Requirements
- R1: After reset every buffer's control word reads 0x0400_0000 (state code 0x4 = empty in bits 27:24). The flag words (0x100, 0x101), the mask words, the lost counter (0x121) and `irq` are all zero.
- R2: An accepted frame goes to the lowest-numbered unlocked buffer whose code is 0x4. Buffers with code 0x0 (inactive), 0x2 (full) or 0x6 (overrun) are skipped.
- R3: A stored frame reads back as follows. The control word holds code 0x2 in bits 27:24, the length in bits 19:16 and the timer value at arrival in bits 15:0. The identifier is at word 1 and the data at words 2 and 3.
- R4: In the cycle between accepting a frame and committing it, the target's code has bit 24 set (0x5 if it was empty, 0x3 if it was full). The commit happens in the following cycle.
- R5: When no buffer is empty, a frame overwrites the most recently filled buffer if that buffer holds code 0x2 or 0x6 and is unlocked. The buffer then holds code 0x6 and the new contents.
- R6: A frame that finds no target is dropped. The lost counter at 0x121 increments by one, saturates, and never decreases.
- R7: A host read of a control word locks that buffer only if its code is not 0x4. Each control-word read releases any earlier lock. A locked buffer is never chosen as a frame target, and an empty buffer is never locked.
- R8: A host read of the timer at 0x120 releases the lock.
- R9: A commit into buffer b sets bit b%32 of flag word 0x100+b/32. Writing ones to a flag word clears those bits, but a flag set in the same cycle wins.
- R10: `irq` is high exactly when some flag bit and the same bit of the mask words (0x110+k) are both set.
- R11: A host write to a control word replaces the whole word. Code 0x0 deactivates the buffer and code 0x4 re-arms it as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received frame is presented this cycle |
| rx_ident | input | 32 | Identifier word of the frame |
| rx_len | input | 4 | Length of the frame |
| rx_data0 | input | 32 | First data word |
| rx_data1 | input | 32 | Second data word |
| hst_en | input | 1 | Host access request |
| hst_wr | input | 1 | 1 = write, 0 = read |
| hst_addr | input | 9 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, one cycle after the read |
| hst_rvalid | output | 1 | Read data valid |
| irq | output | 1 | Masked OR of the buffer flags |

## Verification
On every cycle the assertions check four rules about the bank's state. A locked buffer is never picked as a frame target. An empty-buffer control read and a timer read both leave no lock. A buffer that is being committed still shows its busy code, and its flag is set on the next cycle. The lost counter never goes down. Some behaviour can only be shown by the bench scenarios:
- the lowest-empty ordering, including skipping inactive and re-armed buffers;
- the exact stored words and timestamp window;
- the busy code being visible to a host read;
- overwrite of the last-filled buffer with the overrun code;
- a frame being dropped while that buffer is locked, and accepted again after a timer read.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
    localparam int CODE_LSB = 24;
    localparam int LEN_LSB  = 16;

    localparam logic [3:0] CODE_OFF   = 4'h0;
    localparam logic [3:0] CODE_EMPTY = 4'h4;
    localparam logic [3:0] CODE_FULL  = 4'h2;
    localparam logic [3:0] CODE_OVR   = 4'h6;

    localparam logic [1:0] W_CTRL  = 2'd0;
    localparam logic [1:0] W_IDENT = 2'd1;
    localparam logic [1:0] W_DATA0 = 2'd2;
    localparam logic [1:0] W_DATA1 = 2'd3;

    typedef struct packed {
        logic [31:0] ctrl;
        logic [31:0] ident;
        logic [31:0] data0;
        logic [31:0] data1;
    } mbox_t;

    function automatic logic [3:0] code_of(input logic [31:0] c);
        return c[CODE_LSB +: 4];
    endfunction

    function automatic logic [31:0] with_code(input logic [31:0] c, input logic [3:0] k);
        logic [31:0] r;
        r = c;
        r[CODE_LSB +: 4] = k;
        return r;
    endfunction
endpackage

// File: rtl/rmb_first_set.sv
module rmb_first_set #(
    parameter int N = 64,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest set bit wins: scan downward so the last hit is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/rmb_irq_flags.sv
module rmb_irq_flags #(
    parameter int NUM_BUF = 64,
    localparam int IW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int FW = (NUM_BUF + 31) / 32,
    localparam int FB = FW * 32,
    localparam int KW = (FW > 1) ? $clog2(FW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [KW-1:0] clr_word,
    input  logic [31:0]   clr_bits,
    input  logic          mask_we,
    input  logic [KW-1:0] mask_word,
    input  logic [31:0]   mask_data,
    output logic [FB-1:0] flags,
    output logic [FB-1:0] mask,
    output logic          irq
);
    typedef struct packed {
        logic [FB-1:0] flg;
        logic [FB-1:0] msk;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr_en) begin
            fl_d.flg[32*int'(clr_word) +: 32] = fl_q.flg[32*int'(clr_word) +: 32] & ~clr_bits;
        end
        if (mask_we) begin
            fl_d.msk[32*int'(mask_word) +: 32] = mask_data;
        end
        if (set_en) begin
            fl_d.flg[set_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q.flg;
    assign mask  = fl_q.msk;
    assign irq   = |(fl_q.flg & fl_q.msk);
endmodule

// File: rtl/rmb_bank.sv
module rmb_bank
    import rmb_pkg::*;
#(
    parameter int NUM_BUF = 64,
    parameter int LOST_W  = 16,
    localparam int IW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int AW = IW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [31:0]   rx_ident,
    input  logic [3:0]    rx_len,
    input  logic [31:0]   rx_data0,
    input  logic [31:0]   rx_data1,
    input  logic          hst_en,
    input  logic          hst_wr,
    input  logic [AW-1:0] hst_addr,
    input  logic [31:0]   hst_wdata,
    output logic [31:0]   hst_rdata,
    output logic          hst_rvalid,
    output logic          irq
);
    localparam int RW = IW + 2;
    localparam int FW = (NUM_BUF + 31) / 32;
    localparam int FB = FW * 32;
    localparam int KW = (FW > 1) ? $clog2(FW) : 1;
    localparam int TMR_W = 16;
    localparam logic [RW-1:0] OFF_TMR  = RW'(32);
    localparam logic [RW-1:0] OFF_LOST = RW'(33);

    typedef struct packed {
        mbox_t [NUM_BUF-1:0] mb;
        logic                lk_v;
        logic [IW-1:0]       lk_idx;
        logic                pend_v;
        logic [IW-1:0]       pend_idx;
        mbox_t               pend_mb;
        logic                last_v;
        logic [IW-1:0]       last_idx;
        logic [TMR_W-1:0]    tmr;
        logic [LOST_W-1:0]   lost;
        logic [31:0]         rdata;
        logic                rvalid;
    } st_t;

    st_t st_d, st_q;

    // host address decode
    logic          host_rd, host_wrt, sel_buf, reg_flag, reg_mask;
    logic [IW-1:0] sel_idx;
    logic [1:0]    sel_word;
    logic [RW-1:0] roff;
    logic [KW-1:0] kidx;

    assign host_rd  = hst_en && !hst_wr;
    assign host_wrt = hst_en && hst_wr;
    assign sel_buf  = !hst_addr[AW-1];
    assign sel_idx  = hst_addr[IW+1:2];
    assign sel_word = hst_addr[1:0];
    assign roff     = hst_addr[RW-1:0];
    assign kidx     = roff[KW-1:0];
    assign reg_flag = !sel_buf && (roff[RW-1:4] == '0) && (int'(roff[3:0]) < FW);
    assign reg_mask = !sel_buf && (roff[RW-1:4] == (RW-4)'(1)) && (int'(roff[3:0]) < FW);

    // candidate targets: empty and not held by the host
    logic [NUM_BUF-1:0] empty_vec;
    logic               empty_found;
    logic [IW-1:0]      empty_idx;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_empty
        assign empty_vec[g] = (code_of(st_q.mb[g].ctrl) == CODE_EMPTY)
                           && !(st_q.lk_v && (st_q.lk_idx == IW'(g)));
    end

    rmb_first_set #(.N(NUM_BUF)) u_first (
        .req   (empty_vec),
        .found (empty_found),
        .idx   (empty_idx)
    );

    logic [FB-1:0] flags_vec, mask_vec;

    rmb_irq_flags #(.NUM_BUF(NUM_BUF)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (st_q.pend_v),
        .set_idx   (st_q.pend_idx),
        .clr_en    (host_wrt && reg_flag),
        .clr_word  (kidx),
        .clr_bits  (hst_wdata),
        .mask_we   (host_wrt && reg_mask),
        .mask_word (kidx),
        .mask_data (hst_wdata),
        .flags     (flags_vec),
        .mask      (mask_vec),
        .irq       (irq)
    );

    logic          acc_en;
    logic [IW-1:0] acc_idx;
    logic          acc_ovr;

    always_comb begin
        logic [3:0] last_code;
        logic [3:0] tcode;
        st_d        = st_q;
        st_d.tmr    = st_q.tmr + 1'b1;
        st_d.rvalid = host_rd;
        st_d.rdata  = '0;
        st_d.pend_v = 1'b0;
        acc_en      = 1'b0;
        acc_idx     = '0;
        acc_ovr     = 1'b0;

        // host reads and their lock side effects
        if (host_rd) begin
            if (sel_buf) begin
                case (sel_word)
                    W_CTRL:  st_d.rdata = st_q.mb[sel_idx].ctrl;
                    W_IDENT: st_d.rdata = st_q.mb[sel_idx].ident;
                    W_DATA0: st_d.rdata = st_q.mb[sel_idx].data0;
                    default: st_d.rdata = st_q.mb[sel_idx].data1;
                endcase
                if (sel_word == W_CTRL) begin
                    st_d.lk_v   = (code_of(st_q.mb[sel_idx].ctrl) != CODE_EMPTY);
                    st_d.lk_idx = sel_idx;
                end
            end else if (reg_flag) begin
                st_d.rdata = flags_vec[32*int'(kidx) +: 32];
            end else if (reg_mask) begin
                st_d.rdata = mask_vec[32*int'(kidx) +: 32];
            end else if (roff == OFF_TMR) begin
                st_d.rdata = 32'(st_q.tmr);
                st_d.lk_v  = 1'b0;
            end else if (roff == OFF_LOST) begin
                st_d.rdata = 32'(st_q.lost);
            end
        end

        // host writes to buffer words
        if (host_wrt && sel_buf) begin
            case (sel_word)
                W_CTRL:  st_d.mb[sel_idx].ctrl  = hst_wdata;
                W_IDENT: st_d.mb[sel_idx].ident = hst_wdata;
                W_DATA0: st_d.mb[sel_idx].data0 = hst_wdata;
                default: st_d.mb[sel_idx].data1 = hst_wdata;
            endcase
        end

        // second stage: commit the staged frame (wins over a host write)
        if (st_q.pend_v) begin
            st_d.mb[st_q.pend_idx] = st_q.pend_mb;
        end

        // first stage: choose a target for a new frame
        last_code = code_of(st_q.mb[st_q.last_idx].ctrl);
        if (rx_valid) begin
            if (empty_found) begin
                acc_en  = 1'b1;
                acc_idx = empty_idx;
            end else if (st_q.last_v
                         && ((last_code == CODE_FULL) || (last_code == CODE_OVR))
                         && !(st_q.lk_v && (st_q.lk_idx == st_q.last_idx))) begin
                acc_en  = 1'b1;
                acc_idx = st_q.last_idx;
                acc_ovr = 1'b1;
            end else if (st_q.lost != '1) begin
                st_d.lost = st_q.lost + 1'b1;
            end
        end

        if (acc_en) begin
            tcode = code_of(st_q.mb[acc_idx].ctrl) | 4'h1;
            st_d.mb[acc_idx].ctrl = with_code(st_d.mb[acc_idx].ctrl, tcode);
            st_d.pend_v           = 1'b1;
            st_d.pend_idx         = acc_idx;
            st_d.pend_mb.ctrl     = {4'h0, (acc_ovr ? CODE_OVR : CODE_FULL), 4'h0, rx_len, st_q.tmr};
            st_d.pend_mb.ident    = rx_ident;
            st_d.pend_mb.data0    = rx_data0;
            st_d.pend_mb.data1    = rx_data1;
            st_d.last_v           = 1'b1;
            st_d.last_idx         = acc_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NUM_BUF; i++) begin
                st_q.mb[i].ctrl <= with_code(32'h0, CODE_EMPTY);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign hst_rdata  = st_q.rdata;
    assign hst_rvalid = st_q.rvalid;

    // observation points for the bound checker
    logic          rd_ctrl, rd_tmr, lk_valid, pend_valid;
    logic [IW-1:0] lk_index, pend_index;
    logic [3:0]    sel_code, pend_code;
    logic [LOST_W-1:0] lost_cnt;

    assign rd_ctrl    = host_rd && sel_buf && (sel_word == W_CTRL);
    assign rd_tmr     = host_rd && !sel_buf && (roff == OFF_TMR);
    assign sel_code   = code_of(st_q.mb[sel_idx].ctrl);
    assign lk_valid   = st_q.lk_v;
    assign lk_index   = st_q.lk_idx;
    assign pend_valid = st_q.pend_v;
    assign pend_index = st_q.pend_idx;
    assign pend_code  = code_of(st_q.mb[st_q.pend_idx].ctrl);
    assign lost_cnt   = st_q.lost;
endmodule

// File: rtl/rmb_bank_chk.sv
module rmb_bank_chk #(
    parameter int NUM_BUF = 64,
    parameter int LOST_W  = 16,
    localparam int IW = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int FB = ((NUM_BUF + 31) / 32) * 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ctrl,
    input logic              rd_tmr,
    input logic [3:0]        sel_code,
    input logic              lk_valid,
    input logic [IW-1:0]     lk_index,
    input logic              acc_en,
    input logic [IW-1:0]     acc_idx,
    input logic              pend_valid,
    input logic [IW-1:0]     pend_index,
    input logic [3:0]        pend_code,
    input logic [FB-1:0]     flags_vec,
    input logic [LOST_W-1:0] lost_cnt
);
    assert_empty_never_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && sel_code == 4'h4) |=> !lk_valid);

    assert_locked_not_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> !(lk_valid && lk_index == acc_idx));

    assert_timer_unlocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_tmr |=> !lk_valid);

    assert_busy_before_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> pend_code[0]);

    assert_commit_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |=> flags_vec[$past(pend_index)]);

    assert_lost_monotonic_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lost_cnt >= $past(lost_cnt));
endmodule

bind rmb_bank rmb_bank_chk #(.NUM_BUF(NUM_BUF), .LOST_W(LOST_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ctrl    (rd_ctrl),
    .rd_tmr     (rd_tmr),
    .sel_code   (sel_code),
    .lk_valid   (lk_valid),
    .lk_index   (lk_index),
    .acc_en     (acc_en),
    .acc_idx    (acc_idx),
    .pend_valid (pend_valid),
    .pend_index (pend_index),
    .pend_code  (pend_code),
    .flags_vec  (flags_vec),
    .lost_cnt   (lost_cnt)
);

// File: tb/rmb_bank_bench.sv
`timescale 1ns/1ps
module rmb_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [31:0] rx_ident = '0;
    logic [3:0]  rx_len = '0;
    logic [31:0] rx_data0 = '0;
    logic [31:0] rx_data1 = '0;
    logic        hst_en = 1'b0;
    logic        hst_wr = 1'b0;
    logic [8:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        hst_rvalid;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rmb_bank u_rmb_bank (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ident(rx_ident),
        .rx_len(rx_len), .rx_data0(rx_data0), .rx_data1(rx_data1),
        .hst_en(hst_en), .hst_wr(hst_wr), .hst_addr(hst_addr), .hst_wdata(hst_wdata),
        .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid), .irq(irq)
    );

    localparam logic [8:0] A_FLAG0 = 9'h100;
    localparam logic [8:0] A_FLAG1 = 9'h101;
    localparam logic [8:0] A_MASK0 = 9'h110;
    localparam logic [8:0] A_MASK1 = 9'h111;
    localparam logic [8:0] A_TMR   = 9'h120;
    localparam logic [8:0] A_LOST  = 9'h121;

    function automatic logic [8:0] ba(input int b, input int w);
        return 9'((b << 2) | w);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    task automatic host_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        hst_en = 1'b1; hst_wr = 1'b0; hst_addr = a;
        @(negedge clk);
        hst_en = 1'b0;
        d = hst_rdata;
    endtask

    task automatic host_wrt(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        hst_en = 1'b1; hst_wr = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_en = 1'b0; hst_wr = 1'b0;
    endtask

    task automatic send(input logic [31:0] id, input logic [3:0] len, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_ident = id; rx_len = len; rx_data0 = a; rx_data1 = b;
        @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        host_rd(ba(0, 0), d);  chk("R1", "ctrl buf0 after reset", d, 32'h0400_0000);
        host_rd(ba(63, 0), d); chk("R1", "ctrl buf63 after reset", d, 32'h0400_0000);
        host_rd(A_FLAG0, d);   chk("R1", "flag word 0", d, 32'h0);
        host_rd(A_MASK1, d);   chk("R1", "mask word 1", d, 32'h0);
        host_rd(A_LOST, d);    chk("R1", "lost counter", d, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h1 & 32'h0);
        host_rd(A_TMR, d);
    endtask

    task automatic t_store();
        logic [31:0] d, t0, t1;
        host_rd(A_TMR, t0);
        send(32'h1234_5678, 4'd8, 32'hAABB_CCDD, 32'h1122_3344);
        host_rd(A_TMR, t1);
        host_rd(ba(0, 0), d);
        chk("R3", "ctrl code/len", d & 32'hFFFF_0000, 32'h0208_0000);
        n_chk++;
        if (!(d[15:0] >= t0[15:0] && d[15:0] <= t1[15:0])) begin
            n_fail++;
            $display("FAIL R3 timestamp: actual=0x%04h expected between 0x%04h and 0x%04h", d[15:0], t0[15:0], t1[15:0]);
        end
        host_rd(ba(0, 1), d); chk("R3", "ident word", d, 32'h1234_5678);
        host_rd(ba(0, 2), d); chk("R3", "data0 word", d, 32'hAABB_CCDD);
        host_rd(ba(0, 3), d); chk("R3", "data1 word", d, 32'h1122_3344);
        host_rd(A_TMR, d);
        host_rd(A_FLAG0, d);  chk("R9", "flag bit 0 set", d, 32'h1);
        chk("R10", "irq masked off", {31'b0, irq}, 32'h0);
        host_wrt(A_MASK0, 32'h1);
        chk("R10", "irq with mask bit 0", {31'b0, irq}, 32'h1);
        host_wrt(A_FLAG0, 32'h1);
        host_rd(A_FLAG0, d);  chk("R9", "flag cleared by write-one", d, 32'h0);
        chk("R10", "irq after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_lowest();
        logic [31:0] d;
        host_wrt(ba(2, 0), 32'h0000_0000);
        host_rd(ba(2, 0), d); chk("R11", "buf2 deactivated", d, 32'h0);
        host_rd(A_TMR, d);
        send(32'h0000_0011, 4'd1, 32'h0, 32'h0);
        host_rd(ba(1, 1), d); chk("R2", "first frame to buf1", d, 32'h11);
        send(32'h0000_0033, 4'd1, 32'h0, 32'h0);
        host_rd(ba(3, 1), d); chk("R2", "inactive buf2 skipped", d, 32'h33);
        host_wrt(ba(2, 0), 32'h0400_0000);
        send(32'h0000_0022, 4'd2, 32'h0, 32'h0);
        host_rd(ba(2, 1), d); chk("R11", "re-armed buf2 receives", d, 32'h22);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        @(negedge clk);
        rx_valid = 1'b1; rx_ident = 32'h0000_0044; rx_len = 4'd3;
        @(negedge clk);
        rx_valid = 1'b0;
        hst_en = 1'b1; hst_wr = 1'b0; hst_addr = ba(4, 0);
        @(negedge clk);
        hst_en = 1'b0;
        chk("R4", "busy code seen", 32'(hst_rdata[27:24]), 32'h5);
        @(negedge clk);
        host_rd(ba(4, 0), d); chk("R4", "commit one cycle later", 32'(d[27:24]), 32'h2);
        host_rd(A_TMR, d);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        for (int b = 5; b < 64; b++) send(32'h100 + 32'(b), 4'd4, 32'(b), 32'h0);
        host_rd(A_FLAG1, d); chk("R9", "upper flag word full", d, 32'hFFFF_FFFF);
        host_rd(A_FLAG0, d); chk("R9", "lower flag word", d, 32'hFFFF_FFFE);
        host_wrt(A_MASK1, 32'h20);
        chk("R10", "irq from upper word", {31'b0, irq}, 32'h1);
        send(32'h0000_BEEF, 4'd5, 32'h0, 32'h0);
        host_rd(ba(63, 1), d); chk("R5", "overwrite last buffer", d, 32'hBEEF);
        host_rd(ba(63, 0), d); chk("R5", "overrun code", 32'(d[27:24]), 32'h6);
        host_rd(A_LOST, d);    chk("R5", "no loss on overwrite", d, 32'h0);
        send(32'h0000_DEAD, 4'd5, 32'h0, 32'h0);
        host_rd(A_LOST, d);    chk("R6", "locked target drops frame", d, 32'h1);
        host_rd(ba(63, 1), d); chk("R7", "locked buffer untouched", d, 32'hBEEF);
        host_rd(A_TMR, d);
        send(32'h0000_CAFE, 4'd5, 32'h0, 32'h0);
        host_rd(ba(63, 1), d); chk("R8", "timer read released lock", d, 32'hCAFE);
        host_rd(A_LOST, d);    chk("R6", "lost counter sticky", d, 32'h1);
    endtask

    task automatic t_empty_unlocked();
        logic [31:0] d;
        host_wrt(ba(10, 0), 32'h0400_0000);
        host_rd(ba(10, 0), d); chk("R11", "buf10 re-armed", d, 32'h0400_0000);
        send(32'h0000_0077, 4'd1, 32'h0, 32'h0);
        host_rd(ba(10, 1), d); chk("R7", "empty buffer not locked by read", d, 32'h77);
        host_rd(ba(63, 1), d); chk("R7", "last buffer not overwritten", d, 32'hCAFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_store();
        t_lowest();
        t_busy();
        t_overrun();
        t_empty_unlocked();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule